// File: doc/BRIEF.md
# Audio Clock Source Mode Controller

This block decides where an audio receiver takes its master clock and its serial-output data from. A two-bit mode code chooses between the recovered-clock PLL, the crystal oscillator, an automatic arrangement that falls back to the crystal when the PLL loses lock, and a monitor arrangement. In the monitor arrangement the crystal drives the clocks while the PLL keeps running so that recovered status bits can still be read. From the mode, the live unlock flag and the measured sample rate, the block produces the power enables for both clock sources and the clock-source and data-source selects. It also produces a high-sample-rate indicator with hysteresis.

A second two-bit code sets the frequency ratios of the two master-clock outputs. The block decodes it into one divider code per output. The reserved test value is flagged on its own pin and leaves the last valid setting in place. All outputs are registered, so the downstream glitch-free clock mux and dividers only see selects that change on clock edges. The pins are plain control and status signals; no streaming interface is involved.

Top module: `audio_clk_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs are `pll_en_o`=1, `osc_en_o`=0, `clk_src_xtal_o`=0, `dout_src_aux_o`=0, `fs_hi_o`=0, `mck1_ratio_o`=1 (256fs), `mck2_ratio_o`=1 (256fs), `ratio_test_o`=0 and `ratio_rate_bad_o`=0. The internal rate flag and the held ratio code (00) are cleared as well.
- R2: Mode 00 gives `pll_en_o`=1, `osc_en_o`=0, clock from the PLL (`clk_src_xtal_o`=0), received data (`dout_src_aux_o`=0), and `fs_hi_o` taken from the measured-rate flag.
- R3: Mode 01 gives `pll_en_o`=0, `osc_en_o`=1, clock from the crystal (`clk_src_xtal_o`=1), auxiliary data (`dout_src_aux_o`=1), and `fs_hi_o` equal to `xtal_fs_hi_i`.
- R4: Mode 10 enables both sources. With `pll_unlock_i`=0 the selects and `fs_hi_o` behave as in mode 00. With `pll_unlock_i`=1, clock, data and `fs_hi_o` behave as in mode 01.
- R5: Mode 11 enables both sources and forces `clk_src_xtal_o`=1 and `dout_src_aux_o`=1, with `fs_hi_o` equal to `xtal_fs_hi_i`, whatever the value of `pll_unlock_i`.
- R6: `rate_code_i` is the measured sample rate in units of 100 Hz. The measured-rate flag becomes 1 on an edge where the code is at least 882. It becomes 0 on an edge where the code is at most 540. Otherwise it keeps its value. The flag is updated in every mode.
- R7: Every output reflects the inputs sampled on the previous rising clock edge, which is exactly one register stage.
- R8: Ratio code 00 gives 256fs on both outputs. Code 01 gives 256fs and 128fs. Code 10 gives 512fs and 256fs. Each output is encoded as 0=128fs, 1=256fs, 2=512fs.
- R9: Ratio code 11 sets `ratio_test_o`=1 and leaves both ratio outputs at the last valid setting. Any other code clears the flag.
- R10: `ratio_rate_bad_o` is 1 exactly when the applied setting gives 512fs on the first output and `fs_hi_o` is 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Clock operation mode code |
| ratio_i | input | 2 | Master-clock ratio code |
| pll_unlock_i | input | 1 | 1 while the PLL is not locked |
| rate_code_i | input | RATE_W (11) | Measured sample rate, 100 Hz units |
| xtal_fs_hi_i | input | 1 | Register bit giving the rate indicator in crystal operation |
| pll_en_o | output | 1 | PLL power enable |
| osc_en_o | output | 1 | Crystal oscillator enable |
| clk_src_xtal_o | output | 1 | Master clock source: 0 PLL, 1 crystal |
| dout_src_aux_o | output | 1 | Serial output source: 0 received, 1 auxiliary |
| fs_hi_o | output | 1 | High-sample-rate indicator |
| mck1_ratio_o | output | 2 | First master clock divider code |
| mck2_ratio_o | output | 2 | Second master clock divider code |
| ratio_test_o | output | 1 | Reserved ratio code seen |
| ratio_rate_bad_o | output | 1 | 512fs selected while the rate is high |

## Verification
The mode code is swept through all four values with the unlock flag in both states. This separates the fixed modes from the automatic fallback of mode 10, and shows that mode 11 ignores the unlock flag. Rate codes are drawn around both thresholds: exactly 882, 881, 540 and 541, plus random values. These show set, clear and hold, and show that the flag keeps tracking while `fs_hi_o` is driven from the register bit. Ratio sequences put code 11 between different valid codes, which shows that the previous setting is held rather than reset, and 512fs is combined with a high rate to raise the conflict flag.

// File: rtl/acm_pkg.sv
package acm_pkg;
  localparam int NUM_MCK = 2;

  typedef enum logic [1:0] {
    CM_PLL  = 2'b00,
    CM_XTAL = 2'b01,
    CM_AUTO = 2'b10,
    CM_MON  = 2'b11
  } clk_mode_e;

  typedef enum logic [1:0] {
    DIV_128 = 2'd0,
    DIV_256 = 2'd1,
    DIV_512 = 2'd2,
    DIV_RSV = 2'd3
  } mck_ratio_e;

  typedef struct packed {
    logic pll_en;
    logic osc_en;
    logic clk_xtal;
    logic dat_aux;
    logic fs_reg;
  } src_sel_t;

  // divider code for output idx given a valid ratio selection
  function automatic logic [1:0] ratio_for(input int idx, input logic [1:0] code);
    logic [1:0] r;
    if (idx == 0) r = (code == 2'b10) ? DIV_512 : DIV_256;
    else          r = (code == 2'b01) ? DIV_128 : DIV_256;
    return r;
  endfunction
endpackage

// File: rtl/acm_rate_hyst.sv
module acm_rate_hyst #(
  parameter int RATE_W = 11,
  parameter int HI_TH  = 882,
  parameter int LO_TH  = 540
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_code_i,
  output logic              hi_nxt_o,
  output logic              hi_q_o
);
  localparam logic [RATE_W-1:0] HI_C = RATE_W'(HI_TH);
  localparam logic [RATE_W-1:0] LO_C = RATE_W'(LO_TH);

  logic above, below;
  assign above = rate_code_i >= HI_C;
  assign below = rate_code_i <= LO_C;

  always_comb begin
    hi_nxt_o = hi_q_o;
    if (above)      hi_nxt_o = 1'b1;
    else if (below) hi_nxt_o = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q_o <= 1'b0;
    else        hi_q_o <= hi_nxt_o;
  end

  assert_rate_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code_i >= HI_C) |=> hi_q_o);
  assert_rate_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code_i <= LO_C) |=> !hi_q_o);
  assert_rate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code_i > LO_C && rate_code_i < HI_C) |=> $stable(hi_q_o));
endmodule

// File: rtl/acm_mode_decode.sv
module acm_mode_decode
  import acm_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       pll_unlock_i,
  output src_sel_t   sel_o
);
  always_comb begin
    sel_o = '{pll_en: 1'b1, osc_en: 1'b0, clk_xtal: 1'b0, dat_aux: 1'b0, fs_reg: 1'b0};
    case (clk_mode_e'(mode_i))
      CM_PLL: ;
      CM_XTAL: begin
        sel_o.pll_en   = 1'b0;
        sel_o.osc_en   = 1'b1;
        sel_o.clk_xtal = 1'b1;
        sel_o.dat_aux  = 1'b1;
        sel_o.fs_reg   = 1'b1;
      end
      CM_AUTO: begin
        sel_o.osc_en   = 1'b1;
        sel_o.clk_xtal = pll_unlock_i;
        sel_o.dat_aux  = pll_unlock_i;
        sel_o.fs_reg   = pll_unlock_i;
      end
      CM_MON: begin
        sel_o.osc_en   = 1'b1;
        sel_o.clk_xtal = 1'b1;
        sel_o.dat_aux  = 1'b1;
        sel_o.fs_reg   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acm_ratio_sel.sv
module acm_ratio_sel
  import acm_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                ratio_i,
  output logic [1:0]                held_nxt_o,
  output logic [NUM_MCK-1:0][1:0]   ratio_o,
  output logic                      test_o
);
  logic [1:0] held_q;
  logic       is_test;

  assign is_test    = (ratio_i == 2'b11);
  assign held_nxt_o = is_test ? held_q : ratio_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 2'b00;
      test_o <= 1'b0;
    end else begin
      held_q <= held_nxt_o;
      test_o <= is_test;
    end
  end

  for (genvar g = 0; g < NUM_MCK; g++) begin : g_mck
    assign ratio_o[g] = ratio_for(g, held_q);
  end

  assert_test_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_i == 2'b11) |=> (test_o && $stable(ratio_o)));
  assert_valid_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_i != 2'b11) |=> (!test_o && held_q == $past(ratio_i)));
endmodule

// File: rtl/audio_clk_mode_ctrl.sv
module audio_clk_mode_ctrl
  import acm_pkg::*;
#(
  parameter int RATE_W = 11,
  parameter int HI_TH  = 882,
  parameter int LO_TH  = 540
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        ratio_i,
  input  logic              pll_unlock_i,
  input  logic [RATE_W-1:0] rate_code_i,
  input  logic              xtal_fs_hi_i,
  output logic              pll_en_o,
  output logic              osc_en_o,
  output logic              clk_src_xtal_o,
  output logic              dout_src_aux_o,
  output logic              fs_hi_o,
  output logic [1:0]        mck1_ratio_o,
  output logic [1:0]        mck2_ratio_o,
  output logic              ratio_test_o,
  output logic              ratio_rate_bad_o
);
  src_sel_t                  sel;
  logic                      meas_hi_nxt, meas_hi_q;
  logic                      fs_nxt;
  logic [1:0]                held_nxt;
  logic [NUM_MCK-1:0][1:0]   ratios;

  acm_rate_hyst #(.RATE_W(RATE_W), .HI_TH(HI_TH), .LO_TH(LO_TH)) u_hyst (
    .clk(clk), .rst_n(rst_n), .rate_code_i(rate_code_i),
    .hi_nxt_o(meas_hi_nxt), .hi_q_o(meas_hi_q)
  );

  acm_mode_decode u_dec (
    .mode_i(mode_i), .pll_unlock_i(pll_unlock_i), .sel_o(sel)
  );

  acm_ratio_sel u_ratio (
    .clk(clk), .rst_n(rst_n), .ratio_i(ratio_i),
    .held_nxt_o(held_nxt), .ratio_o(ratios), .test_o(ratio_test_o)
  );

  assign mck1_ratio_o = ratios[0];
  assign mck2_ratio_o = ratios[1];
  assign fs_nxt = sel.fs_reg ? xtal_fs_hi_i : meas_hi_nxt;

  // all selects registered so the clock mux sees clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_en_o         <= 1'b1;
      osc_en_o         <= 1'b0;
      clk_src_xtal_o   <= 1'b0;
      dout_src_aux_o   <= 1'b0;
      fs_hi_o          <= 1'b0;
      ratio_rate_bad_o <= 1'b0;
    end else begin
      pll_en_o         <= sel.pll_en;
      osc_en_o         <= sel.osc_en;
      clk_src_xtal_o   <= sel.clk_xtal;
      dout_src_aux_o   <= sel.dat_aux;
      fs_hi_o          <= fs_nxt;
      ratio_rate_bad_o <= (held_nxt == 2'b10) && fs_nxt;
    end
  end

  assert_mode0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00) |=> (pll_en_o && !osc_en_o && !clk_src_xtal_o && !dout_src_aux_o
                           && fs_hi_o == meas_hi_q));
  assert_mode1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01) |=> (!pll_en_o && osc_en_o && clk_src_xtal_o && dout_src_aux_o
                           && fs_hi_o == $past(xtal_fs_hi_i)));
  assert_fallback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && pll_unlock_i) |=> (pll_en_o && osc_en_o && clk_src_xtal_o
                           && dout_src_aux_o && fs_hi_o == $past(xtal_fs_hi_i)));
  assert_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && !pll_unlock_i) |=> (!clk_src_xtal_o && !dout_src_aux_o
                           && fs_hi_o == meas_hi_q));
  assert_monitor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11) |=> (pll_en_o && osc_en_o && clk_src_xtal_o && dout_src_aux_o));
  assert_bad_rate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_rate_bad_o |-> (mck1_ratio_o == DIV_512 && fs_hi_o));
  assert_enable_any_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_en_o || osc_en_o));
endmodule

// File: tb/audio_clk_mode_ctrl_test.sv
`timescale 1ns/1ps
module audio_clk_mode_ctrl_test;
  localparam int RW = 11;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00, ratio = 2'b00;
  logic unlock = 1'b0, xfs = 1'b0;
  logic [RW-1:0] rate = '0;
  logic pll_en, osc_en, clk_x, dat_a, fs_hi, r_test, r_bad;
  logic [1:0] m1, m2;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic m_hi = 1'b0;
  logic [1:0] m_held = 2'b00;

  audio_clk_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .ratio_i(ratio), .pll_unlock_i(unlock),
    .rate_code_i(rate), .xtal_fs_hi_i(xfs), .pll_en_o(pll_en), .osc_en_o(osc_en),
    .clk_src_xtal_o(clk_x), .dout_src_aux_o(dat_a), .fs_hi_o(fs_hi),
    .mck1_ratio_o(m1), .mck2_ratio_o(m2), .ratio_test_o(r_test), .ratio_rate_bad_o(r_bad)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic hyst(input logic prev, input logic [RW-1:0] r);
    if (r >= 882) return 1'b1;
    if (r <= 540) return 1'b0;
    return prev;
  endfunction

  // apply inputs now (after negedge), clock once, compare at next negedge
  task automatic step(input logic [1:0] md, input logic [1:0] ro, input logic ul,
                      input logic [RW-1:0] rc, input logic xf);
    logic xsel, e_fs;
    logic [1:0] e1, e2;
    mode = md; ratio = ro; unlock = ul; rate = rc; xfs = xf;
    m_hi = hyst(m_hi, rc);
    xsel = (md == 2'b01) || (md == 2'b11) || (md == 2'b10 && ul);
    e_fs = xsel ? xf : m_hi;
    if (ro != 2'b11) m_held = ro;
    e1 = (m_held == 2'b10) ? 2'd2 : 2'd1;
    e2 = (m_held == 2'b01) ? 2'd0 : 2'd1;
    @(posedge clk);
    @(negedge clk);
    chk(pll_en == (md != 2'b01), "R2/R3 pll_en", pll_en, md != 2'b01);
    chk(osc_en == (md != 2'b00), "R3/R5 osc_en", osc_en, md != 2'b00);
    chk(clk_x == xsel, "R4/R5 clk_src", clk_x, xsel);
    chk(dat_a == xsel, "R4/R5 dout_src", dat_a, xsel);
    chk(fs_hi == e_fs, "R6/R7 fs_hi", fs_hi, e_fs);
    chk(m1 == e1, "R8 mck1", m1, e1);
    chk(m2 == e2, "R8 mck2", m2, e2);
    chk(r_test == (ro == 2'b11), "R9 test flag", r_test, ro == 2'b11);
    chk(r_bad == (m_held == 2'b10 && e_fs), "R10 rate bad", r_bad, m_held == 2'b10 && e_fs);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pll_en == 1 && osc_en == 0 && clk_x == 0 && dat_a == 0, "R1 sources", {pll_en,osc_en,clk_x,dat_a}, 4'b1000);
    chk(fs_hi == 0 && r_test == 0 && r_bad == 0, "R1 flags", {fs_hi,r_test,r_bad}, 0);
    chk(m1 == 1 && m2 == 1, "R1 ratios", {m1,m2}, 4'b0101);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 thresholds in mode 0
    step(2'b00, 2'b00, 0, 11'd881, 0);  // hold low
    step(2'b00, 2'b00, 0, 11'd882, 0);  // set
    step(2'b00, 2'b00, 0, 11'd541, 0);  // hold high
    step(2'b00, 2'b00, 0, 11'd540, 1);  // clear
    // R4 fallback, R5 monitor ignores unlock
    step(2'b10, 2'b00, 0, 11'd960, 0);
    step(2'b10, 2'b00, 1, 11'd700, 0);
    step(2'b10, 2'b00, 0, 11'd700, 0);
    step(2'b11, 2'b01, 0, 11'd300, 1);
    step(2'b11, 2'b01, 1, 11'd300, 0);
    // R3 flag keeps tracking while fs_hi follows register bit
    step(2'b01, 2'b01, 0, 11'd960, 0);
    step(2'b00, 2'b01, 0, 11'd700, 0);
    // R9 hold across test code, R10 conflict
    step(2'b00, 2'b10, 0, 11'd960, 0);
    step(2'b00, 2'b11, 0, 11'd960, 0);
    step(2'b01, 2'b11, 0, 11'd960, 1);
    step(2'b01, 2'b01, 0, 11'd960, 1);
    step(2'b00, 2'b11, 0, 11'd960, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [RW-1:0] rc;
      case ($urandom % 3)
        0: rc = RW'(530 + $urandom % 22);
        1: rc = RW'(872 + $urandom % 22);
        default: rc = RW'($urandom);
      endcase
      step(2'($urandom), 2'($urandom), 1'($urandom), rc, 1'($urandom));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule